// File: doc/BRIEF.md
# Serial PCM Voice Port

A slave-mode serial port for one voice channel. An external 8 kHz frame sync marks the start of every frame, and a bit clock at 64 kHz × N (N = 1 to 32) times the bits. The bit clock must stay locked to the frame sync. Both are sampled in the block's system clock domain. In each frame the port shifts one sample out on the transmit pin and captures one sample from the receive pin. Bit periods after the sample slot carry nothing.

A single format pin is classified as one of three states, once per frame. Held low, it selects an 8-bit A-law slot. Held high, it selects an 8-bit u-law slot. Wired to the frame sync, it selects a 16-bit two's-complement slot that carries a 14-bit value in its upper bits. An alignment pin chooses where the MSB sits: in the bit period that starts with the frame sync rising edge, or in the next bit period.

Toward the codec core, transmit samples enter through a valid/ready stream and received samples leave through a valid/ready stream. Both carry a 14-bit word. In the 8-bit formats only the low byte of that word is used. The companding arithmetic itself belongs to the core.

Top module: `pcm_voice_port`

## Requirements
- R1: While reset is held, `tx_oe`, `tx_pin` and `m_rx_valid` are low and `s_tx_ready` is high.
- R2: With `align_sel` high, the MSB is launched on the bit clock rising edge that coincides with the frame sync rising edge. With `align_sel` low, it is launched on the next rising bit clock edge.
- R3: The transmit slot is shifted MSB first, and `tx_pin` changes only after a rising bit clock edge. `tx_oe` is high for exactly the slot length in bit periods (8 or 16), and `tx_pin` is low whenever `tx_oe` is low.
- R4: The format pin is read at each frame sync rising edge and at the falling edge that follows. Low at both edges selects A-law (8-bit slot). High at both edges selects u-law (8-bit slot). High at the rise and low at the fall selects linear (16-bit slot). Any other reading yields no class. The format after reset is A-law.
- R5: A new format takes effect only after the same class has been read in two consecutive frames. A slot uses the format that is in force when the slot starts.
- R6: In the linear format, the 16-bit transmit word is `{s_tx_data[13:0], 2'b00}`. The received word's bits [15:2] appear on `m_rx_data`, and its two lowest bits are discarded.
- R7: In the 8-bit formats, `s_tx_data[7:0]` is sent MSB first. The received byte appears on `m_rx_data[7:0]` with bits [13:8] zero.
- R8: Receive bits are sampled on falling bit clock edges while a slot is active. `m_rx_valid` rises in the system clock cycle after the falling edge that captures the last bit.
- R9: One holding register sits behind `s_tx_ready`, which is high while that register is empty. A transfer (`s_tx_valid` and `s_tx_ready` both high) fills the register, and the start of a slot empties it. A slot that starts with the register empty sends all zeros.
- R10: `m_rx_valid` stays high with `m_rx_data` unchanged until `m_rx_ready` is seen high. A sample that completes while the previous one is still waiting replaces it.
- R11: A frame sync rising edge during an unfinished slot starts the new frame's slot. The old transmit slot is cut short, and its partly received sample is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than twice the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock |
| fsync | input | 1 | 8 kHz frame sync |
| fmt_sel | input | 1 | Format pin: low, high or wired to `fsync` |
| align_sel | input | 1 | 1: MSB at frame sync edge, 0: one bit later |
| rx_pin | input | 1 | Serial receive data |
| tx_pin | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Transmit pad enable, high during the slot only |
| s_tx_valid | input | 1 | Transmit sample offered |
| s_tx_ready | output | 1 | Holding register empty |
| s_tx_data | input | 14 | Transmit sample (linear word or low byte) |
| m_rx_valid | output | 1 | Received sample available |
| m_rx_ready | input | 1 | Core takes the received sample |
| m_rx_data | output | 14 | Received sample |

## Verification
The bench builds the port with its default widths: a 14-bit core word, a 16-bit linear slot and an 8-bit companded slot. It drives bit clocks of 64 kHz × 4, × 2 and × 1 relative to a frame. With ×2, a 16-bit slot delayed by one bit runs into the next frame's first bit period. With ×1, a linear slot is longer than the frame, so the restart path is exercised. The format pin is switched between all three states, and each switch is followed over several frames so that the two-frame confirmation can be seen. Received words include both full-scale values and the 0 dBm0 peak, with their two lowest bits set to nonzero values.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  typedef enum logic [1:0] {
    FMT_ALAW = 2'd0,
    FMT_ULAW = 2'd1,
    FMT_LIN  = 2'd2
  } fmt_e;
endpackage

// File: rtl/pcm_edge_sync.sv
// Registers asynchronous-looking strobes twice and reports single-cycle
// rising and falling events in the system clock domain.
module pcm_edge_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig_in,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= sig_in;
      stage2 <= stage1;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_edge
    assign rise[i] = stage1[i] & ~stage2[i];
    assign fall[i] = ~stage1[i] & stage2[i];
  end
endmodule

// File: rtl/pcm_fmt_detect.sv
// Classifies the three-state format pin from its level at the frame sync
// rising and falling edges, and commits a class seen in two frames running.
module pcm_fmt_detect
  import pcm_port_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fs_rise,
  input  logic fs_fall,
  input  logic lvl,
  output fmt_e fmt
);
  logic lvl_at_rise;
  logic cand_ok;
  fmt_e cand;
  logic cls_ok;
  fmt_e cls;

  always_comb begin
    cls_ok = 1'b1;
    cls    = FMT_ALAW;
    unique case ({lvl_at_rise, lvl})
      2'b00:   cls = FMT_ALAW;
      2'b11:   cls = FMT_ULAW;
      2'b10:   cls = FMT_LIN;
      default: cls_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_at_rise <= 1'b0;
      cand_ok     <= 1'b0;
      cand        <= FMT_ALAW;
      fmt         <= FMT_ALAW;
    end else begin
      if (fs_rise) lvl_at_rise <= lvl;
      if (fs_fall) begin
        cand    <= cls;
        cand_ok <= cls_ok;
        if (cls_ok && cand_ok && (cls == cand)) fmt <= cls;
      end
    end
  end
endmodule

// File: rtl/pcm_tx_path.sv
// Holding register on the transmit stream, slot start decision and the
// MSB-first output shifter.
module pcm_tx_path
  import pcm_port_pkg::*;
#(
  parameter int LIN_W    = 14,
  parameter int SLOT_LIN = 16,
  parameter int SLOT_LAW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fs_rise,
  input  logic             bclk_rise,
  input  logic             align,
  input  fmt_e             fmt,
  input  logic             s_tx_valid,
  output logic             s_tx_ready,
  input  logic [LIN_W-1:0] s_tx_data,
  output logic             tx_pin,
  output logic             tx_oe,
  output logic             slot_start,
  output logic             slot_lin
);
  localparam int PAD = SLOT_LIN - LIN_W;
  localparam int GAP = SLOT_LIN - SLOT_LAW;
  localparam int CW  = $clog2(SLOT_LIN + 1);

  logic                armed, active, full;
  logic [LIN_W-1:0]    hold;
  logic [SLOT_LIN-1:0] shreg;
  logic [CW-1:0]       left;
  logic [SLOT_LIN-1:0] load_word;
  logic                accept;

  assign slot_start = (fs_rise & align) | (armed & bclk_rise & ~fs_rise);
  assign slot_lin   = (fmt == FMT_LIN);
  assign accept     = s_tx_valid & ~full;
  assign s_tx_ready = ~full;

  always_comb begin
    if (!full)         load_word = '0;
    else if (slot_lin) load_word = {hold, {PAD{1'b0}}};
    else               load_word = {hold[SLOT_LAW-1:0], {GAP{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      active <= 1'b0;
      full   <= 1'b0;
      hold   <= '0;
      shreg  <= '0;
      left   <= '0;
    end else begin
      if (fs_rise)         armed <= ~align;
      else if (slot_start) armed <= 1'b0;

      if (slot_start) begin
        shreg  <= load_word;
        active <= 1'b1;
        left   <= slot_lin ? CW'(SLOT_LIN - 1) : CW'(SLOT_LAW - 1);
      end else if (active && bclk_rise) begin
        if (left == '0) begin
          active <= 1'b0;
        end else begin
          shreg <= {shreg[SLOT_LIN-2:0], 1'b0};
          left  <= left - 1'b1;
        end
      end

      if (accept) begin
        full <= 1'b1;
        hold <= s_tx_data;
      end else if (slot_start) begin
        full <= 1'b0;
      end
    end
  end

  assign tx_oe  = active;
  assign tx_pin = active & shreg[SLOT_LIN-1];
endmodule

// File: rtl/pcm_rx_path.sv
// Falling-edge capture of the receive slot and the output stream register.
module pcm_rx_path #(
  parameter int LIN_W    = 14,
  parameter int SLOT_LIN = 16,
  parameter int SLOT_LAW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_start,
  input  logic             slot_lin,
  input  logic             bclk_fall,
  input  logic             rx_bit,
  output logic             m_rx_valid,
  input  logic             m_rx_ready,
  output logic [LIN_W-1:0] m_rx_data
);
  localparam int CW  = $clog2(SLOT_LIN + 1);
  localparam int EXT = LIN_W - SLOT_LAW;

  logic                busy, lin_q, last;
  logic [SLOT_LIN-1:0] shreg, word_nxt;
  logic [CW-1:0]       left;

  assign word_nxt = {shreg[SLOT_LIN-2:0], rx_bit};
  assign last     = busy & bclk_fall & (left == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      lin_q <= 1'b0;
      shreg <= '0;
      left  <= '0;
    end else if (slot_start) begin
      busy  <= 1'b1;
      lin_q <= slot_lin;
      shreg <= '0;
      left  <= slot_lin ? CW'(SLOT_LIN) : CW'(SLOT_LAW);
    end else if (busy && bclk_fall) begin
      shreg <= word_nxt;
      left  <= left - 1'b1;
      if (last) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rx_valid <= 1'b0;
      m_rx_data  <= '0;
    end else if (last) begin
      m_rx_valid <= 1'b1;
      m_rx_data  <= lin_q ? word_nxt[SLOT_LIN-1 -: LIN_W]
                          : {{EXT{1'b0}}, word_nxt[SLOT_LAW-1:0]};
    end else if (m_rx_valid && m_rx_ready) begin
      m_rx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
  import pcm_port_pkg::*;
#(
  parameter int LIN_W    = 14,
  parameter int SLOT_LIN = 16,
  parameter int SLOT_LAW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk,
  input  logic             fsync,
  input  logic             fmt_sel,
  input  logic             align_sel,
  input  logic             rx_pin,
  output logic             tx_pin,
  output logic             tx_oe,
  input  logic             s_tx_valid,
  output logic             s_tx_ready,
  input  logic [LIN_W-1:0] s_tx_data,
  output logic             m_rx_valid,
  input  logic             m_rx_ready,
  output logic [LIN_W-1:0] m_rx_data
);
  logic [1:0] rise_v, fall_v;
  logic       bclk_rise, bclk_fall, fs_rise, fs_fall;
  logic       fmt_q, align_q, rx_q;
  logic       slot_start, slot_lin;
  fmt_e       fmt_cur;

  pcm_edge_sync #(.W(2)) u_edges (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_in ({fsync, bclk}),
    .rise   (rise_v),
    .fall   (fall_v)
  );

  assign bclk_rise = rise_v[0];
  assign bclk_fall = fall_v[0];
  assign fs_rise   = rise_v[1];
  assign fs_fall   = fall_v[1];

  // Level inputs take the same single register stage as the edge sampler.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q   <= 1'b0;
      align_q <= 1'b0;
      rx_q    <= 1'b0;
    end else begin
      fmt_q   <= fmt_sel;
      align_q <= align_sel;
      rx_q    <= rx_pin;
    end
  end

  pcm_fmt_detect u_fmt (
    .clk     (clk),
    .rst_n   (rst_n),
    .fs_rise (fs_rise),
    .fs_fall (fs_fall),
    .lvl     (fmt_q),
    .fmt     (fmt_cur)
  );

  pcm_tx_path #(.LIN_W(LIN_W), .SLOT_LIN(SLOT_LIN), .SLOT_LAW(SLOT_LAW)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .fs_rise    (fs_rise),
    .bclk_rise  (bclk_rise),
    .align      (align_q),
    .fmt        (fmt_cur),
    .s_tx_valid (s_tx_valid),
    .s_tx_ready (s_tx_ready),
    .s_tx_data  (s_tx_data),
    .tx_pin     (tx_pin),
    .tx_oe      (tx_oe),
    .slot_start (slot_start),
    .slot_lin   (slot_lin)
  );

  pcm_rx_path #(.LIN_W(LIN_W), .SLOT_LIN(SLOT_LIN), .SLOT_LAW(SLOT_LAW)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_start (slot_start),
    .slot_lin   (slot_lin),
    .bclk_fall  (bclk_fall),
    .rx_bit     (rx_q),
    .m_rx_valid (m_rx_valid),
    .m_rx_ready (m_rx_ready),
    .m_rx_data  (m_rx_data)
  );
endmodule

// File: rtl/pcm_voice_port_chk.sv
module pcm_voice_port_chk (
  input logic clk,
  input logic rst_n,
  input logic bclk_rise,
  input logic bclk_fall,
  input logic slot_start,
  input logic tx_pin,
  input logic s_tx_valid,
  input logic s_tx_ready,
  input logic m_rx_valid,
  input logic m_rx_ready
);
  // R3: the serial output only moves after a rising bit clock event
  p_tx_moves_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_pin) |-> $past(bclk_rise));

  // R8: a received sample appears only after a falling bit clock event
  p_rx_after_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_rx_valid) |-> $past(bclk_fall));

  // R9: a transfer fills the holding register
  p_ready_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s_tx_valid && s_tx_ready |=> !s_tx_ready);

  // R9: the holding register empties only at a slot start
  p_ready_rises_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_tx_ready) |-> $past(slot_start));

  // R10: a waiting received sample is kept while the core stalls
  p_rx_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_rx_valid && !m_rx_ready |=> m_rx_valid);
endmodule

bind pcm_voice_port pcm_voice_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bclk_rise  (bclk_rise),
  .bclk_fall  (bclk_fall),
  .slot_start (slot_start),
  .tx_pin     (tx_pin),
  .s_tx_valid (s_tx_valid),
  .s_tx_ready (s_tx_ready),
  .m_rx_valid (m_rx_valid),
  .m_rx_ready (m_rx_ready)
);

// File: tb/pcm_voice_port_test.sv
`timescale 1ns/1ps
module pcm_voice_port_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, fsync = 1'b0, fmt_sel = 1'b0, align_sel = 1'b0, rx_pin = 1'b0;
  logic tx_pin, tx_oe, s_tx_ready, m_rx_valid;
  logic s_tx_valid = 1'b0, m_rx_ready = 1'b1;
  logic [13:0] s_tx_data = '0;
  logic [13:0] m_rx_data;

  pcm_voice_port uut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .fmt_sel(fmt_sel),
    .align_sel(align_sel), .rx_pin(rx_pin), .tx_pin(tx_pin), .tx_oe(tx_oe),
    .s_tx_valid(s_tx_valid), .s_tx_ready(s_tx_ready), .s_tx_data(s_tx_data),
    .m_rx_valid(m_rx_valid), .m_rx_ready(m_rx_ready), .m_rx_data(m_rx_data)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // stimulus generator state
  int ph = 0, frame = 0, hb = 2, nmul = 4, fmode = 0;
  bit align = 1, bp = 0, skip = 0;
  string tag_oe = "R3";
  logic [15:0] rxw = '0;
  bit tx_acc_q = 0;

  // inputs(k-1) and inputs(k-2) as seen by the model
  logic cb = 0, cf = 0, cfmt = 0, cal = 0, crx = 0;
  logic pb = 0, pf = 0;

  // reference model state
  int m_cur = 0, m_cand = 0, m_left = 0, r_left = 0;
  bit m_cand_ok = 0, m_rise_lvl = 0, m_armed = 0, m_active = 0, m_full = 0;
  bit r_busy = 0, r_lin = 0, e_valid = 0, e_lin = 0;
  logic [15:0] m_word = '0, r_sh = '0;
  logic [13:0] m_hold = '0, e_data = '0;

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] pick(input int i);
    case (i % 4)
      0: pick = {14'h1FFF, 2'b11};
      1: pick = {14'h2000, 2'b01};
      2: pick = {14'h164A, 2'b10};
      default: pick = 16'($urandom);
    endcase
  endfunction

  task automatic tick();
    bit br, bf, fr, ff, start, lin, acc_tx, acc_rx, last, cls_ok;
    int cls, flen, bitn, j;
    logic [15:0] nsh;
    @(negedge clk);
    // compare design outputs with the model, every clock
    chk(tag_oe, "tx_oe", 16'(tx_oe), 16'(m_active));
    chk((m_cur == 2) ? "R6" : "R7", "tx_pin", 16'(tx_pin), 16'(m_active & m_word[15]));
    chk("R9", "s_tx_ready", 16'(s_tx_ready), 16'(!m_full));
    chk(bp ? "R10" : "R8", "m_rx_valid", 16'(m_rx_valid), 16'(e_valid));
    if (e_valid) chk(e_lin ? "R6" : "R7", "m_rx_data", 16'(m_rx_data), 16'(e_data));

    // stream handshakes for this cycle
    flen = 16 * hb * nmul;
    if (tx_acc_q) s_tx_valid = 1'b0;
    if (ph == 8 * hb && !s_tx_valid && !(skip && frame % 3 == 2)) begin
      s_tx_valid = 1'b1;
      s_tx_data  = pick(frame + 1)[15:2];
    end
    m_rx_ready = !(bp && frame >= 1 && frame <= 3);
    acc_tx = s_tx_valid && !m_full;
    tx_acc_q = acc_tx;
    acc_rx = e_valid && m_rx_ready;

    // model advance with the inputs driven one cycle earlier
    br = cb & !pb; bf = !cb & pb; fr = cf & !pf; ff = !cf & pf;
    start = (fr && cal) || (m_armed && br && !fr);
    lin = (m_cur == 2);
    last = 0; nsh = '0;
    if (start) begin
      m_word = !m_full ? 16'h0 : (lin ? {m_hold, 2'b00} : {m_hold[7:0], 8'h00});
      m_active = 1; m_left = lin ? 15 : 7;
      r_busy = 1; r_lin = lin; r_left = lin ? 16 : 8; r_sh = '0;
    end else begin
      if (m_active && br) begin
        if (m_left == 0) m_active = 0;
        else begin m_word = m_word << 1; m_left--; end
      end
      if (r_busy && bf) begin
        nsh = {r_sh[14:0], crx}; r_sh = nsh; r_left--;
        if (r_left == 0) begin r_busy = 0; last = 1; end
      end
    end
    if (fr) m_armed = !cal; else if (start) m_armed = 0;
    if (acc_tx) begin m_full = 1; m_hold = s_tx_data; end
    else if (start) m_full = 0;
    if (last) begin
      e_valid = 1; e_lin = r_lin;
      e_data = r_lin ? nsh[15:2] : {6'b0, nsh[7:0]};
    end else if (acc_rx) e_valid = 0;
    if (fr) m_rise_lvl = cfmt;
    if (ff) begin
      cls_ok = 1; cls = 0;
      if (m_rise_lvl && cfmt) cls = 1;
      else if (!m_rise_lvl && !cfmt) cls = 0;
      else if (m_rise_lvl && !cfmt) cls = 2;
      else cls_ok = 0;
      if (cls_ok && m_cand_ok && cls == m_cand) m_cur = cls;
      m_cand = cls; m_cand_ok = cls_ok;
    end

    // next input values
    pb = cb; pf = cf;
    if (ph == 0) rxw = pick(frame);
    bitn = ph / (2 * hb);
    cb = (ph % (2 * hb)) < hb;
    cf = (bitn == 0);
    cfmt = (fmode == 2) ? cf : (fmode == 1);
    cal = align;
    j = bitn - (align ? 0 : 1);
    crx = (j >= 0 && j < 16) ? rxw[15 - j] : 1'($urandom);
    bclk = cb; fsync = cf; fmt_sel = cfmt; align_sel = cal; rx_pin = crx;
    ph++;
    if (ph == flen) begin ph = 0; frame++; end
  endtask

  task automatic scenario(input int fm, input bit al, input int n,
                          input string tg, input bit bpv, input bit skv);
    fmode = fm; align = al; nmul = n; tag_oe = tg; bp = bpv; skip = skv;
    frame = 0; ph = 0;
    while (frame < 6) tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "tx_oe", 16'(tx_oe), 16'h0);
    chk("R1", "tx_pin", 16'(tx_pin), 16'h0);
    chk("R1", "m_rx_valid", 16'(m_rx_valid), 16'h0);
    chk("R1", "s_tx_ready", 16'(s_tx_ready), 16'h1);
    rst_n = 1'b1;
    scenario(0, 1, 4, "R4", 0, 0);  // A-law, MSB at frame edge
    scenario(1, 0, 4, "R5", 1, 0);  // switch to u-law, delayed MSB, stalled core
    scenario(2, 1, 4, "R2", 0, 1);  // linear, frames with no transmit sample
    scenario(2, 0, 4, "R3", 0, 0);  // linear, delayed MSB
    scenario(0, 0, 2, "R4", 0, 0);  // A-law on a short frame
    scenario(2, 1, 2, "R2", 0, 0);  // linear slot fills the frame exactly
    scenario(2, 1, 1, "R11", 0, 0); // linear slot longer than the frame
    scenario(1, 1, 4, "R5", 0, 0);  // back to u-law
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule